// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic core of a small 8-bit processor datapath. It owns an accumulator, two index registers, a result register and a status byte. When its valid input is high on a clock edge, it runs one operation on the accumulator and an 8-bit memory operand. The operation is add-with-carry, bitwise AND, shift left of the accumulator or shift left of the memory operand. It then registers the new result and the updated condition flags. The instruction decoder and memory interface sit outside the block. They supply an operation code and an operand each cycle and read the result and status back one edge later.

The status byte uses a fixed layout: carry, zero, overflow and negative. Its four middle bits are fixed at their reset values. A shift of the memory operand writes only the result register, so the accumulator keeps its value for the instructions that follow.

Top module: `alu8_core`

## Requirements
- R1: While rst_n is low, and at the first sample after rst_n rises, result_o, x_o and y_o are 0x00, status_o is 0x22 and the accumulator is 0x00.
- R2: Status bit 0 is carry (C), bit 1 is zero (Z), bit 6 is overflow (V) and bit 7 is negative (N). Bits 5..2 keep their reset value 4'b1000 through every operation.
- R3: Opcode 3'b000 (add) forms the 9-bit sum A + M + C. Its low 8 bits go into both the accumulator and result_o, and C takes bit 8, so C=1 exactly when the sum is 256 or more. Outputs change at the clock edge where valid_i is high.
- R4: After an add, V=1 exactly when A and M have the same bit 7 and the sum's bit 7 differs from it; otherwise V=0.
- R5: Opcode 3'b001 (and) writes A & M to both the accumulator and result_o. It updates Z and N and leaves C and V unchanged.
- R6: Opcode 3'b010 (shift accumulator) copies A[7] into C and writes A<<1, with 0 entering bit 0, to both the accumulator and result_o. V is unchanged.
- R7: Opcode 3'b011 (shift memory) copies M[7] into C and writes M<<1 to result_o only. The accumulator and V are unchanged.
- R8: After each of the four operations, Z=1 exactly when the 8-bit value written to result_o is zero, and N equals bit 7 of that value.
- R9: When valid_i is low at a clock edge, the accumulator, result_o and status_o keep their values.
- R10: An opcode with bit 2 set is unrecognized and changes no state.
- R11: x_o and y_o stay 0x00 after reset, since no operation writes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Perform the operation on this edge |
| op_i | input | 3 | Operation code |
| mem_i | input | 8 | Memory operand M |
| result_o | output | 8 | Result register |
| x_o | output | 8 | X index register |
| y_o | output | 8 | Y index register |
| status_o | output | 8 | Status byte {N,V,1,0,0,0,Z,C} |

## Verification
The bench sweeps add over every memory operand, against accumulator values spread across the full range and with both carry-in values. This covers the carry boundary, including 0xFF+0x00+1 and 0xFF+0x01+0. A design that compares the sum against 256 with a strict greater-than would clear carry on an exact 256. A design that ignores the carry-in would give results one too low. Overflow is checked on every sign combination, which catches a sign test taken from the wrong operand. Shifts of the memory operand are followed by an add of zero, so an accumulator wrongly overwritten by the shift shows up in the next result. Idle cycles and unrecognized opcodes are checked for drift in the result or flags.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int W = 8;

    localparam int FLAG_C = 0;
    localparam int FLAG_Z = 1;
    localparam int FLAG_V = 6;
    localparam int FLAG_N = 7;

    localparam logic [W-1:0] STATUS_RST = 8'b0010_0010;

    typedef enum logic [2:0] {
        OP_ADC   = 3'b000,
        OP_AND   = 3'b001,
        OP_SHL_A = 3'b010,
        OP_SHL_M = 3'b011
    } op_e;

    typedef struct packed {
        logic [W-1:0] acc;
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic [W-1:0] res;
        logic [W-1:0] status;
    } state_t;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [W:0] full;

    always_comb begin
        full   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        sum_o  = full[W-1:0];
        cout_o = full[W];
        ovf_o  = (a_i[W-1] == b_i[W-1]) && (full[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/alu8_shl.sv
module alu8_shl #(
    parameter int W = 8
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] val_o,
    output logic         out_bit_o
);
    assign val_o     = {val_i[W-2:0], 1'b0};
    assign out_bit_o = val_i[W-1];
endmodule

// File: rtl/alu8_zn.sv
module alu8_zn #(
    parameter int W = 8
) (
    input  logic [W-1:0] val_i,
    output logic         zero_o,
    output logic         neg_o
);
    assign zero_o = (val_i == '0);
    assign neg_o  = val_i[W-1];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [2:0]   op_i,
    input  logic [W-1:0] mem_i,
    output logic [W-1:0] result_o,
    output logic [W-1:0] x_o,
    output logic [W-1:0] y_o,
    output logic [W-1:0] status_o
);
    localparam int NSRC = 2;

    state_t st_d, st_q;

    logic [W-1:0] sum;
    logic         cout, ovf;
    logic [W-1:0] shl_val [NSRC];
    logic         shl_bit [NSRC];
    logic [W-1:0] shl_src [NSRC];
    logic [W-1:0] wr_val;
    logic         wr_zero, wr_neg;

    alu8_adder #(.W(W)) u_add (
        .a_i   (st_q.acc),
        .b_i   (mem_i),
        .cin_i (st_q.status[FLAG_C]),
        .sum_o (sum),
        .cout_o(cout),
        .ovf_o (ovf)
    );

    assign shl_src[0] = st_q.acc;
    assign shl_src[1] = mem_i;

    for (genvar g = 0; g < NSRC; g++) begin : g_shl
        alu8_shl #(.W(W)) u_shl (
            .val_i    (shl_src[g]),
            .val_o    (shl_val[g]),
            .out_bit_o(shl_bit[g])
        );
    end

    always_comb begin
        wr_val = st_q.res;
        case (op_i)
            OP_ADC:   wr_val = sum;
            OP_AND:   wr_val = st_q.acc & mem_i;
            OP_SHL_A: wr_val = shl_val[0];
            OP_SHL_M: wr_val = shl_val[1];
            default:  wr_val = st_q.res;
        endcase
    end

    alu8_zn #(.W(W)) u_zn (
        .val_i (wr_val),
        .zero_o(wr_zero),
        .neg_o (wr_neg)
    );

    always_comb begin
        st_d = st_q;
        if (valid_i) begin
            case (op_i)
                OP_ADC: begin
                    st_d.acc            = wr_val;
                    st_d.res            = wr_val;
                    st_d.status[FLAG_C] = cout;
                    st_d.status[FLAG_V] = ovf;
                    st_d.status[FLAG_Z] = wr_zero;
                    st_d.status[FLAG_N] = wr_neg;
                end
                OP_AND: begin
                    st_d.acc            = wr_val;
                    st_d.res            = wr_val;
                    st_d.status[FLAG_Z] = wr_zero;
                    st_d.status[FLAG_N] = wr_neg;
                end
                OP_SHL_A: begin
                    st_d.acc            = wr_val;
                    st_d.res            = wr_val;
                    st_d.status[FLAG_C] = shl_bit[0];
                    st_d.status[FLAG_Z] = wr_zero;
                    st_d.status[FLAG_N] = wr_neg;
                end
                OP_SHL_M: begin
                    st_d.res            = wr_val;
                    st_d.status[FLAG_C] = shl_bit[1];
                    st_d.status[FLAG_Z] = wr_zero;
                    st_d.status[FLAG_N] = wr_neg;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.acc    <= '0;
            st_q.x      <= '0;
            st_q.y      <= '0;
            st_q.res    <= '0;
            st_q.status <= STATUS_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.res;
    assign x_o      = st_q.x;
    assign y_o      = st_q.y;
    assign status_o = st_q.status;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         valid_i,
    input logic [2:0]   op_i,
    input logic [W-1:0] mem_i,
    input logic [W-1:0] result_o,
    input logic [W-1:0] x_o,
    input logic [W-1:0] y_o,
    input logic [W-1:0] status_o
);
    assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[5:2] == 4'b1000);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(result_o) && $stable(status_o));

    assert_bad_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && op_i[2] |=> $stable(result_o) && $stable(status_o));

    assert_index_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        x_o == '0 && y_o == '0);

    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && !op_i[2] |=> status_o[FLAG_Z] == (result_o == '0));

    assert_neg_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && !op_i[2] |=> status_o[FLAG_N] == result_o[W-1]);

    assert_and_keeps_cv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && op_i == OP_AND |=> $stable(status_o[FLAG_C]) && $stable(status_o[FLAG_V]));

    assert_shl_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && op_i == OP_SHL_M |=>
            status_o[FLAG_C] == $past(mem_i[W-1]) && result_o == {$past(mem_i[W-2:0]), 1'b0});
endmodule

bind alu8_core alu8_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .op_i    (op_i),
    .mem_i   (mem_i),
    .result_o(result_o),
    .x_o     (x_o),
    .y_o     (y_o),
    .status_o(status_o)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid_i = 1'b0;
    logic [2:0] op_i = 3'b000;
    logic [7:0] mem_i = 8'h00;
    logic [7:0] result_o, x_o, y_o, status_o;

    int checks = 0;
    int fails  = 0;

    logic [7:0] m_a   = 8'h00;
    logic [7:0] m_res = 8'h00;
    logic [7:0] m_st  = 8'h22;

    always #4 clk = ~clk;

    alu8_core u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_i),
        .op_i    (op_i),
        .mem_i   (mem_i),
        .result_o(result_o),
        .x_o     (x_o),
        .y_o     (y_o),
        .status_o(status_o)
    );

    task automatic compare(input string req);
        checks++;
        if (result_o !== m_res || status_o !== m_st || x_o !== 8'h00 || y_o !== 8'h00) begin
            fails++;
            $display("FAIL %s: res=%h st=%b x=%h y=%h expected res=%h st=%b x=00 y=00",
                     req, result_o, status_o, x_o, y_o, m_res, m_st);
        end
    endtask

    task automatic model(input logic v, input logic [2:0] op, input logic [7:0] m);
        logic [8:0] s;
        logic [7:0] w;
        if (!v || op[2]) return;
        case (op)
            3'b000: begin
                s = {1'b0, m_a} + {1'b0, m} + {8'd0, m_st[0]};
                w = s[7:0];
                m_st[0] = (s >= 9'd256);
                m_st[6] = (m_a[7] == m[7]) && (w[7] != m_a[7]);
                m_a = w;
            end
            3'b001: begin w = m_a & m; m_a = w; end
            3'b010: begin m_st[0] = m_a[7]; w = m_a * 2; m_a = w; end
            default: begin m_st[0] = m[7]; w = m * 2; end
        endcase
        m_res   = w;
        m_st[1] = (w == 8'h00);
        m_st[7] = w[7];
    endtask

    task automatic apply(input logic v, input logic [2:0] op, input logic [7:0] m, input string req);
        valid_i = v;
        op_i    = op;
        mem_i   = m;
        model(v, op, m);
        @(posedge clk);
        @(negedge clk);
        compare(req);
    endtask

    task automatic load_acc(input logic [7:0] a, input logic cin);
        apply(1'b1, 3'b001, 8'h00, "R5");
        apply(1'b1, 3'b011, 8'h00, "R7");
        apply(1'b1, 3'b000, a, "R3");
        apply(1'b1, 3'b011, cin ? 8'h80 : 8'h00, "R7");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        // R3 R4: add sweep, accumulator spread over range, every operand, both carry-ins
        for (int a = 0; a < 256; a += 17) begin
            for (int cin = 0; cin < 2; cin++) begin
                for (int m = 0; m < 256; m++) begin
                    load_acc(a[7:0], cin[0]);
                    apply(1'b1, 3'b000, m[7:0], "R3/R4 add");
                end
            end
        end

        // R3 explicit carry boundaries
        load_acc(8'hFF, 1'b1);
        apply(1'b1, 3'b000, 8'h00, "R3 FF+00+1");
        load_acc(8'hFF, 1'b0);
        apply(1'b1, 3'b000, 8'h01, "R3 FF+01+0");

        // R5: AND with carry and overflow preset
        for (int a = 0; a < 256; a += 5) begin
            load_acc(8'h7F, 1'b1);
            apply(1'b1, 3'b000, 8'h01, "R4 set V");
            apply(1'b1, 3'b000, a[7:0], "R3");
            for (int m = 0; m < 256; m += 3)
                apply(1'b1, 3'b001, m[7:0], "R5 and");
        end

        // R6: accumulator shift
        for (int a = 0; a < 256; a++) begin
            load_acc(a[7:0], a[0]);
            apply(1'b1, 3'b010, 8'h5A, "R6 shl acc");
            apply(1'b1, 3'b010, 8'h00, "R6 shl acc twice");
        end

        // R7: memory shift keeps accumulator; following add of 0 exposes it
        for (int m = 0; m < 256; m++) begin
            load_acc(8'h3C, 1'b0);
            apply(1'b1, 3'b011, m[7:0], "R7 shl mem");
            apply(1'b1, 3'b011, 8'h00, "R7 clear C");
            apply(1'b1, 3'b000, 8'h00, "R7 acc kept");
        end

        // R8: zero and negative values
        load_acc(8'h00, 1'b0);
        apply(1'b1, 3'b000, 8'h00, "R8 zero");
        apply(1'b1, 3'b000, 8'h80, "R8 negative");

        // R9: idle cycles with changing inputs
        load_acc(8'hC3, 1'b1);
        for (int k = 0; k < 32; k++) begin
            apply(1'b0, k[1:0], 8'(k * 37), "R9 idle");
        end
        apply(1'b1, 3'b000, 8'h00, "R9 acc after idle");

        // R10: unrecognized opcodes
        load_acc(8'h81, 1'b1);
        for (int k = 4; k < 8; k++) begin
            apply(1'b1, k[2:0], 8'hFF, "R10 bad op");
        end
        apply(1'b1, 3'b000, 8'h00, "R10 acc after bad op");

        // R11, R2: index registers and fixed bits checked at every compare; final explicit
        checks++;
        if (status_o[5:2] !== 4'b1000) begin
            fails++;
            $display("FAIL R2: bits5..2=%b expected 1000", status_o[5:2]);
        end
        compare("R11 index regs");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule